// File: doc/BRIEF.md
# GPIO Pin Resolution and Input Sampling Datapath

This block sits between the configuration registers of a general-purpose I/O bank and its pads. It holds the per-pin output value, polarity, output enable, open-drain select, pull-up, pull-down and input mask registers. From these and from an external drive description (one driven flag and one level per pin), it works out the level each pin settles to. It flags pins that two drivers fight over and pins that float with no pull. It also forms the polarity-corrected input data word.

Software sets and clears single bits of the output value and output enable through dedicated alias offsets, so no read-modify-write is needed. The input data word is registered one clock after pins or configuration change. The value it held the cycle before is presented next to it, so a downstream event detector can compare the two. Slew-rate, drive-strength, blink and debounce settings are held and read back only; they do not affect the pins.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: A pin with output enable set and open-drain clear is driven to (output value XOR polarity), and with no external driver its level equals that value.
- R2: With open-drain set, a pin is driven only when its drive value is 0; with drive value 1 it is released and behaves as undriven.
- R3: A pin driven both internally and externally to opposite levels raises its conflict flag and resolves to level 1; no conflict is flagged otherwise.
- R4: An externally driven pin with no internal drive takes the external level; an undriven pin reads 1 if its pull-up is set (pull-up wins over pull-down) and 0 if only pull-down is set.
- R5: An undriven pin with neither pull enabled raises its undefined flag and reads level 0; the undefined flag never coincides with a conflict.
- R6: Input data equals (pin level AND input mask) XOR polarity, appears on din_o one clock after the change, and din_prev_o always holds the din_o value of the previous cycle.
- R7: A write to byte offset 0x68 ORs the data into the output value, 0x6C clears the written bits of it, and 0x70 and 0x74 do the same for the output enable; the aliases read as 0.
- R8: Reset clears every register except pull-up, pull-down, slew-rate and drive-strength, which load the RST_PULLUP, RST_PULLDN, RST_SLEW and RST_STRENGTH parameters.
- R9: Register map (byte offsets): output value 0x00, polarity 0x04, output enable 0x08, open-drain 0x0C, pull-up 0x10, pull-down 0x14, input mask 0x18, slew 0x1C, strength 0x20, blink 0x24, debounce 0x28, input data 0x2C (read-only); every writable register reads back what was written.
- R10: Writes to the slew, strength, blink and debounce registers do not change any pin output; writes to the input data offset or to an unmapped offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset for write and read |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data for addr_i (combinational) |
| ext_drv_i | input | NPINS | Per-pin external driver present |
| ext_lvl_i | input | NPINS | Per-pin external driver level |
| pin_lvl_o | output | NPINS | Resolved pin level |
| pin_undef_o | output | NPINS | Pin floating with no pull |
| pin_conflict_o | output | NPINS | Pin driven to opposite levels |
| din_o | output | NPINS | Registered input data |
| din_prev_o | output | NPINS | din_o from the previous cycle |

## Verification
On every cycle the assertions check that a conflicting pin reads 1, that a floating pin reads 0 and is never also in conflict, that push-pull driven pins follow the drive value, that din_prev_o trails din_o by one clock, and that the set and clear aliases land in the stored registers. Only the bench's sweep shows the full resolution truth table per pin, including open-drain release, pull priority, masking and polarity of the input word. Its directed scenarios alone show the reset defaults, readback, alias arithmetic and that writes to stored-only, read-only and unmapped offsets leave the pins and registers untouched.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam logic [7:0] OFS_DOUT     = 8'h00;
  localparam logic [7:0] OFS_POL      = 8'h04;
  localparam logic [7:0] OFS_OE       = 8'h08;
  localparam logic [7:0] OFS_OD       = 8'h0C;
  localparam logic [7:0] OFS_PU       = 8'h10;
  localparam logic [7:0] OFS_PD       = 8'h14;
  localparam logic [7:0] OFS_IEM      = 8'h18;
  localparam logic [7:0] OFS_SLEW     = 8'h1C;
  localparam logic [7:0] OFS_STR      = 8'h20;
  localparam logic [7:0] OFS_BLINK    = 8'h24;
  localparam logic [7:0] OFS_DBNC     = 8'h28;
  localparam logic [7:0] OFS_DIN      = 8'h2C;
  localparam logic [7:0] OFS_DOUT_SET = 8'h68;
  localparam logic [7:0] OFS_DOUT_CLR = 8'h6C;
  localparam logic [7:0] OFS_OE_SET   = 8'h70;
  localparam logic [7:0] OFS_OE_CLR   = 8'h74;

  typedef struct packed {
    logic dout;
    logic pol;
    logic oe;
    logic od;
    logic pu;
    logic pd;
    logic iem;
  } pin_cfg_t;

  typedef struct packed {
    logic lvl;
    logic undef;
    logic conflict;
    logic din;
  } pin_res_t;
endpackage

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NPINS        = 32,
  parameter int unsigned ADDR_W       = 8,
  parameter logic [NPINS-1:0] RST_PU  = '0,
  parameter logic [NPINS-1:0] RST_PD  = '0,
  parameter logic [NPINS-1:0] RST_SLEW = '0,
  parameter logic [NPINS-1:0] RST_STR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  din_i,
  output pin_cfg_t [NPINS-1:0] cfg_o,
  output logic [NPINS-1:0]  dout_o,
  output logic [NPINS-1:0]  oe_o,
  output logic [NPINS-1:0]  od_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  rdata_o
);
  logic [NPINS-1:0] dout_q, pol_q, oe_q, od_q, pu_q, pd_q, iem_q;
  logic [NPINS-1:0] slew_q, str_q, blink_q, dbnc_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      pol_q   <= '0;
      oe_q    <= '0;
      od_q    <= '0;
      pu_q    <= RST_PU;
      pd_q    <= RST_PD;
      iem_q   <= '0;
      slew_q  <= RST_SLEW;
      str_q   <= RST_STR;
      blink_q <= '0;
      dbnc_q  <= '0;
    end else if (wr_en_i) begin
      if (hit(addr_i, OFS_DOUT))     dout_q  <= wdata_i;
      if (hit(addr_i, OFS_POL))      pol_q   <= wdata_i;
      if (hit(addr_i, OFS_OE))       oe_q    <= wdata_i;
      if (hit(addr_i, OFS_OD))       od_q    <= wdata_i;
      if (hit(addr_i, OFS_PU))       pu_q    <= wdata_i;
      if (hit(addr_i, OFS_PD))       pd_q    <= wdata_i;
      if (hit(addr_i, OFS_IEM))      iem_q   <= wdata_i;
      if (hit(addr_i, OFS_SLEW))     slew_q  <= wdata_i;
      if (hit(addr_i, OFS_STR))      str_q   <= wdata_i;
      if (hit(addr_i, OFS_BLINK))    blink_q <= wdata_i;
      if (hit(addr_i, OFS_DBNC))     dbnc_q  <= wdata_i;
      if (hit(addr_i, OFS_DOUT_SET)) dout_q  <= dout_q | wdata_i;
      if (hit(addr_i, OFS_DOUT_CLR)) dout_q  <= dout_q & ~wdata_i;
      if (hit(addr_i, OFS_OE_SET))   oe_q    <= oe_q | wdata_i;
      if (hit(addr_i, OFS_OE_CLR))   oe_q    <= oe_q & ~wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, OFS_DOUT))  rdata_o = dout_q;
    if (hit(addr_i, OFS_POL))   rdata_o = pol_q;
    if (hit(addr_i, OFS_OE))    rdata_o = oe_q;
    if (hit(addr_i, OFS_OD))    rdata_o = od_q;
    if (hit(addr_i, OFS_PU))    rdata_o = pu_q;
    if (hit(addr_i, OFS_PD))    rdata_o = pd_q;
    if (hit(addr_i, OFS_IEM))   rdata_o = iem_q;
    if (hit(addr_i, OFS_SLEW))  rdata_o = slew_q;
    if (hit(addr_i, OFS_STR))   rdata_o = str_q;
    if (hit(addr_i, OFS_BLINK)) rdata_o = blink_q;
    if (hit(addr_i, OFS_DBNC))  rdata_o = dbnc_q;
    if (hit(addr_i, OFS_DIN))   rdata_o = din_i;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_cfg
    assign cfg_o[p] = '{dout: dout_q[p], pol: pol_q[p], oe: oe_q[p], od: od_q[p],
                        pu: pu_q[p], pd: pd_q[p], iem: iem_q[p]};
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;
  assign od_o   = od_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/gpio_pad_resolve.sv
module gpio_pad_resolve
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  pin_cfg_t [NPINS-1:0] cfg_i,
  input  logic [NPINS-1:0]     ext_drv_i,
  input  logic [NPINS-1:0]     ext_lvl_i,
  output pin_res_t [NPINS-1:0] res_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic drv_val, int_en, floating, lvl;
    assign drv_val  = cfg_i[p].dout ^ cfg_i[p].pol;
    // open drain: a 1 releases the pad
    assign int_en   = cfg_i[p].oe & ~(cfg_i[p].od & drv_val);
    assign floating = ~(int_en | ext_drv_i[p]);
    assign lvl      = (ext_drv_i[p] & ext_lvl_i[p]) | (int_en & drv_val)
                    | (floating & cfg_i[p].pu);
    assign res_o[p].lvl      = lvl;
    assign res_o[p].conflict = int_en & ext_drv_i[p] & (drv_val ^ ext_lvl_i[p]);
    assign res_o[p].undef    = floating & ~(cfg_i[p].pu | cfg_i[p].pd);
    assign res_o[p].din      = (lvl & cfg_i[p].iem) ^ cfg_i[p].pol;
  end
endmodule

// File: rtl/gpio_pad_sample.sv
module gpio_pad_sample #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] din_d_i,
  output logic [NPINS-1:0] din_o,
  output logic [NPINS-1:0] din_prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_o      <= '0;
      din_prev_o <= '0;
    end else begin
      din_o      <= din_d_i;
      din_prev_o <= din_o;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NPINS             = 32,
  parameter int unsigned ADDR_W            = 8,
  parameter logic [NPINS-1:0] RST_PULLUP   = '0,
  parameter logic [NPINS-1:0] RST_PULLDN   = '0,
  parameter logic [NPINS-1:0] RST_SLEW     = '0,
  parameter logic [NPINS-1:0] RST_STRENGTH = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  ext_drv_i,
  input  logic [NPINS-1:0]  ext_lvl_i,
  output logic [NPINS-1:0]  pin_lvl_o,
  output logic [NPINS-1:0]  pin_undef_o,
  output logic [NPINS-1:0]  pin_conflict_o,
  output logic [NPINS-1:0]  din_o,
  output logic [NPINS-1:0]  din_prev_o
);
  pin_cfg_t [NPINS-1:0] cfg;
  pin_res_t [NPINS-1:0] res;
  logic [NPINS-1:0] dout_q, oe_q, od_q, pol_q, din_d;

  gpio_pad_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .RST_PU(RST_PULLUP), .RST_PD(RST_PULLDN),
    .RST_SLEW(RST_SLEW), .RST_STR(RST_STRENGTH)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .din_i(din_o), .cfg_o(cfg), .dout_o(dout_q),
    .oe_o(oe_q), .od_o(od_q), .pol_o(pol_q), .rdata_o(rdata_o)
  );

  gpio_pad_resolve #(.NPINS(NPINS)) u_resolve (
    .cfg_i(cfg), .ext_drv_i(ext_drv_i), .ext_lvl_i(ext_lvl_i), .res_o(res)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_out
    assign pin_lvl_o[p]      = res[p].lvl;
    assign pin_undef_o[p]    = res[p].undef;
    assign pin_conflict_o[p] = res[p].conflict;
    assign din_d[p]          = res[p].din;
  end

  gpio_pad_sample #(.NPINS(NPINS)) u_sample (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_d_i(din_d),
    .din_o(din_o), .din_prev_o(din_prev_o)
  );
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic [NPINS-1:0]  ext_drv_i,
  input logic [NPINS-1:0]  pin_lvl_o,
  input logic [NPINS-1:0]  pin_undef_o,
  input logic [NPINS-1:0]  pin_conflict_o,
  input logic [NPINS-1:0]  din_o,
  input logic [NPINS-1:0]  din_prev_o,
  input logic [NPINS-1:0]  dout_q,
  input logic [NPINS-1:0]  oe_q,
  input logic [NPINS-1:0]  od_q,
  input logic [NPINS-1:0]  pol_q
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  // R1
  push_pull_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_lvl_o ^ (dout_q ^ pol_q)) & oe_q & ~od_q & ~ext_drv_i) == '0);

  // R3
  conflict_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_conflict_o & ~pin_lvl_o) == '0);

  // R5
  undef_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_undef_o & (pin_lvl_o | pin_conflict_o)) == '0);

  // R6
  din_prev_trail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> din_prev_o == $past(din_o));

  // R7
  dout_set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFS_DOUT_SET)) |=> ((dout_q & $past(wdata_i)) == $past(wdata_i)));

  // R7
  oe_clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFS_OE_CLR)) |=> ((oe_q & $past(wdata_i)) == '0));
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .ext_drv_i(ext_drv_i), .pin_lvl_o(pin_lvl_o),
  .pin_undef_o(pin_undef_o), .pin_conflict_o(pin_conflict_o), .din_o(din_o),
  .din_prev_o(din_prev_o), .dout_q(dout_q), .oe_q(oe_q), .od_q(od_q), .pol_q(pol_q)
);

// File: tb/gpio_pad_ctrl_bench.sv
module gpio_pad_ctrl_bench;
  localparam int N = 4;
  localparam int AW = 8;
  localparam logic [N-1:0] P_PU  = 4'b1010;
  localparam logic [N-1:0] P_PD  = 4'b0110;
  localparam logic [N-1:0] P_SLW = 4'b0011;
  localparam logic [N-1:0] P_STR = 4'b1100;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0] wdata = '0, ext_drv = '0, ext_lvl = '0;
  logic [N-1:0] rdata, pin_lvl, pin_undef, pin_conf, din, din_prev;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_pad_ctrl #(.NPINS(N), .ADDR_W(AW), .RST_PULLUP(P_PU), .RST_PULLDN(P_PD),
                  .RST_SLEW(P_SLW), .RST_STRENGTH(P_STR)) u_gpio_pad_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_drv_i(ext_drv), .ext_lvl_i(ext_lvl), .pin_lvl_o(pin_lvl),
    .pin_undef_o(pin_undef), .pin_conflict_o(pin_conf), .din_o(din), .din_prev_o(din_prev)
  );

  task automatic chk(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string what, input logic [7:0] a, input logic [N-1:0] exp);
    addr = AW'(a);
    #1;
    chk(what, rdata, exp);
  endtask

  // bits: 0 dout 1 pol 2 oe 3 od 4 pu 5 pd 6 iem 7 ext_drv 8 ext_lvl
  // result: {din, conflict, undef, lvl}
  function automatic logic [3:0] model(input logic [8:0] c);
    logic v, en, fl, pin;
    v   = c[0] ^ c[1];
    en  = c[2] & ~(c[3] & v);
    fl  = ~(en | c[7]);
    pin = (c[7] & c[8]) | (en & v) | (fl & c[4]);
    return {(pin & c[6]) ^ c[1], en & c[7] & (v ^ c[8]), fl & ~(c[4] | c[5]), pin};
  endfunction

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog act=running exp=finished");
    bad++; total++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] e_lvl, e_und, e_cnf, e_din;
    logic [N-1:0] v_dout, v_pol, v_oe, v_od, v_pu, v_pd, v_iem;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    rd("R8 pullup", 8'h10, P_PU);
    rd("R8 pulldown", 8'h14, P_PD);
    rd("R8 slew", 8'h1C, P_SLW);
    rd("R8 strength", 8'h20, P_STR);
    rd("R8 dout", 8'h00, '0);
    rd("R8 oe", 8'h08, '0);
    rd("R8 debounce", 8'h28, '0);
    chk("R8/R4 reset pins", pin_lvl, 4'b1010);
    chk("R8/R5 reset undef", pin_undef, 4'b0001);
    chk("R8 reset din", din, '0);

    // R9 readback
    wr(8'h24, 4'b0110); rd("R9 blink rb", 8'h24, 4'b0110);
    wr(8'h18, 4'b1001); rd("R9 mask rb", 8'h18, 4'b1001);
    wr(8'h0C, 4'b0101); rd("R9 od rb", 8'h0C, 4'b0101);
    wr(8'h0C, 4'b0000);

    // R7 aliases
    wr(8'h00, 4'b0101);
    wr(8'h68, 4'b0010); rd("R7 dout set", 8'h00, 4'b0111);
    wr(8'h6C, 4'b0100); rd("R7 dout clr", 8'h00, 4'b0011);
    wr(8'h08, 4'b1000);
    wr(8'h70, 4'b0001); rd("R7 oe set", 8'h08, 4'b1001);
    wr(8'h74, 4'b1000); rd("R7 oe clr", 8'h08, 4'b0001);
    rd("R7 alias reads zero", 8'h68, '0);
    rd("R7 alias reads zero", 8'h74, '0);

    // R10 ignored writes: pins fixed, registers unchanged
    @(negedge clk); #1;
    e_lvl = pin_lvl;
    wr(8'h1C, 4'b1111); wr(8'h20, 4'b0000); wr(8'h24, 4'b1111); wr(8'h28, 4'b1111);
    #1; chk("R10 stored-only no pin effect", pin_lvl, e_lvl);
    e_din = din;
    wr(8'h2C, ~e_din); rd("R10 din write ignored", 8'h2C, e_din);
    wr(8'h40, 4'b1111);
    rd("R10 unmapped dout", 8'h00, 4'b0011);
    rd("R10 unmapped oe", 8'h08, 4'b0001);
    rd("R10 unmapped pu", 8'h10, P_PU);
    rd("R10 unmapped iem", 8'h18, 4'b1001);

    // R2 directed: open drain drive 1 with no pulls floats
    wr(8'h10, 4'b0000); wr(8'h14, 4'b0000); wr(8'h0C, 4'b0001);
    wr(8'h08, 4'b0001); wr(8'h00, 4'b0001); wr(8'h04, 4'b0000);
    #1; chk("R2 od release lvl", pin_lvl & 4'b0001, 4'b0000);
    chk("R2 od release undef", pin_undef & 4'b0001, 4'b0001);
    wr(8'h00, 4'b0000);
    #1; chk("R2 od drive low", pin_undef & 4'b0001, 4'b0000);

    // sweep all per-pin configs on every pin
    for (int c = 0; c < 512; c++) begin
      logic [8:0] cf [N];
      logic [N-1:0] vd, vl;
      for (int p = 0; p < N; p++) begin
        cf[p] = 9'((c + p * 97) % 512);
        v_dout[p] = cf[p][0]; v_pol[p] = cf[p][1]; v_oe[p] = cf[p][2];
        v_od[p] = cf[p][3]; v_pu[p] = cf[p][4]; v_pd[p] = cf[p][5];
        v_iem[p] = cf[p][6]; vd[p] = cf[p][7]; vl[p] = cf[p][8];
        {e_din[p], e_cnf[p], e_und[p], e_lvl[p]} = model(cf[p]);
      end
      wr(8'h00, v_dout); wr(8'h04, v_pol); wr(8'h08, v_oe); wr(8'h0C, v_od);
      wr(8'h10, v_pu); wr(8'h14, v_pd); wr(8'h18, v_iem);
      ext_drv = vd; ext_lvl = vl;
      #1;
      chk("R1/R2/R4 pin level", pin_lvl, e_lvl);
      chk("R3 conflict", pin_conf, e_cnf);
      chk("R5 undefined", pin_undef, e_und);
      @(negedge clk);
      chk("R6 din", din, e_din);
      @(negedge clk);
      chk("R6 din_prev", din_prev, e_din);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end
endmodule